// File: doc/BRIEF.md
# Configuration Packet Command Interpreter

This block takes a configuration bitstream one bit at a time while the configuration-load instruction is selected. It assembles the bits into 32-bit words, most significant bit first. It then treats each word as either a packet header or the data word for the register that the previous header selected. It keeps an options register and a command register. It reacts to two command codes: one arms the device for startup, the other asks for the running CRC to be cleared.

The device leaves configuration mode and enters user mode only when both of these have happened, in this order: a start command has been written, and then the separate start instruction arrives. The test-access state machine, the CRC arithmetic and the frame memory are outside this block. It only signals the CRC clear with a one-cycle pulse.

Top module: `cfg_packet_engine`

## Requirements
- R1: After reset the device is in configuration mode. The options register, the command register, the error flag, the armed flag and the CRC-clear pulse are all zero.
- R2: A bit is taken only when load-select, shift-enable and configuration mode are all true. Bits fill the word MSB first. The word is acted on in the cycle after its 32nd bit.
- R3: Header 0x30012001 sends the next word to the options register, which keeps it bit-exact (for example 0x00A03FFF).
- R4: Header 0x30008001 sends the next word to the command register, which keeps it as written.
- R5: Command value 5 sets the armed flag, and the flag stays set until reset.
- R6: Command value 7 raises the CRC-clear output for exactly one cycle.
- R7: An all-zero word in header position changes no register and no flag.
- R8: In header position, a word that is neither zero nor a supported header sets a sticky error flag and is otherwise ignored. A header is supported only if bits 31:29 = 001, bits 28:27 = 10 (write), bits 10:0 = 1, and bits 17:13 = 9 (options) or 4 (command). The word after an ignored one is read as a header again.
- R9: A start instruction while armed switches to user mode on the next clock edge. User mode holds until reset.
- R10: A start instruction while not armed leaves the device in configuration mode.
- R11: In user mode, shifted bits have no effect on any register.
- R12: Bits shifted while load-select is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_sel_i | input | 1 | Configuration-load instruction is selected |
| shift_en_i | input | 1 | Shift a bit this cycle |
| bit_i | input | 1 | Serial bitstream data |
| start_instr_i | input | 1 | Start instruction strobe |
| user_mode_o | output | 1 | Device is in user mode |
| opt_reg_o | output | 32 | Options register |
| cmd_reg_o | output | 32 | Last command written |
| armed_o | output | 1 | Start command has been seen |
| crc_clear_o | output | 1 | One-cycle CRC clear pulse |
| hdr_err_o | output | 1 | Sticky unsupported-header flag |

## Verification
The 32nd bit is captured on one rising edge, and the register updates, flags and the CRC pulse appear one edge later. The bench therefore waits for exactly one extra rising edge after the last bit and samples at the falling edge that follows. A start instruction changes the mode on the edge that samples it, so the mode is read at the next falling edge. The CRC pulse is checked high at that falling edge and low one cycle later, which makes a pulse stretched by a single cycle visible.

// File: rtl/cfg_pkg.sv
`timescale 1ns/1ps
package cfg_pkg;
  localparam int WORD_W   = 32;
  localparam int CNT_W    = $clog2(WORD_W);
  localparam logic [2:0] PKT_TYPE1 = 3'b001;
  localparam logic [1:0] OP_WRITE  = 2'b10;
  localparam logic [4:0] ADDR_OPT  = 5'd9;
  localparam logic [4:0] ADDR_CMD  = 5'd4;
  localparam logic [10:0] WC_ONE   = 11'd1;
  localparam logic [WORD_W-1:0] CMD_START = 32'd5;
  localparam logic [WORD_W-1:0] CMD_RCRC  = 32'd7;

  typedef enum logic [1:0] {TGT_NONE, TGT_OPT, TGT_CMD} tgt_e;
endpackage

// File: rtl/cfg_deser.sv
`timescale 1ns/1ps
module cfg_deser #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         take_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o,
  output logic         word_vld_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q       <= '0;
      cnt_q      <= '0;
      word_vld_o <= 1'b0;
    end else begin
      word_vld_o <= 1'b0;
      if (take_i) begin
        sr_q <= {sr_q[W-2:0], bit_i};
        if (cnt_q == LAST) begin
          cnt_q      <= '0;
          word_vld_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign word_o = sr_q;
endmodule

// File: rtl/cfg_hdr_decode.sv
`timescale 1ns/1ps
module cfg_hdr_decode
  import cfg_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] word_i,
  output tgt_e         tgt_o,
  output logic         flush_o,
  output logic         bad_o
);
  logic [2:0]  ptype;
  logic [1:0]  op;
  logic [4:0]  addr;
  logic [10:0] wc;
  logic        fmt_ok;

  assign ptype  = word_i[31:29];
  assign op     = word_i[28:27];
  assign addr   = word_i[17:13];
  assign wc     = word_i[10:0];
  assign fmt_ok = (ptype == PKT_TYPE1) && (op == OP_WRITE) && (wc == WC_ONE);

  always_comb begin
    flush_o = (word_i == '0);
    tgt_o   = TGT_NONE;
    bad_o   = 1'b0;
    if (!flush_o) begin
      if (fmt_ok && addr == ADDR_OPT)      tgt_o = TGT_OPT;
      else if (fmt_ok && addr == ADDR_CMD) tgt_o = TGT_CMD;
      else                                 bad_o = 1'b1;
    end
  end
endmodule

// File: rtl/cfg_exec.sv
`timescale 1ns/1ps
module cfg_exec
  import cfg_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         word_vld_i,
  input  logic [W-1:0] word_i,
  input  tgt_e         tgt_i,
  input  logic         bad_i,
  output logic [W-1:0] opt_o,
  output logic [W-1:0] cmd_o,
  output logic         armed_o,
  output logic         crc_clr_o,
  output logic         err_o
);
  tgt_e pend_q;  // TGT_NONE: expecting header

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= TGT_NONE;
      opt_o     <= '0;
      cmd_o     <= '0;
      armed_o   <= 1'b0;
      crc_clr_o <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      crc_clr_o <= 1'b0;
      if (word_vld_i) begin
        unique case (pend_q)
          TGT_OPT: begin
            opt_o  <= word_i;
            pend_q <= TGT_NONE;
          end
          TGT_CMD: begin
            cmd_o  <= word_i;
            pend_q <= TGT_NONE;
            if (word_i == CMD_START) armed_o   <= 1'b1;
            if (word_i == CMD_RCRC)  crc_clr_o <= 1'b1;
          end
          default: begin
            pend_q <= tgt_i;
            if (bad_i) err_o <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_mode_ctrl.sv
`timescale 1ns/1ps
module cfg_mode_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic armed_i,
  output logic user_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 user_o <= 1'b0;
    else if (start_i && armed_i) user_o <= 1'b1;
  end
endmodule

// File: rtl/cfg_packet_engine.sv
`timescale 1ns/1ps
module cfg_packet_engine
  import cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_sel_i,
  input  logic              shift_en_i,
  input  logic              bit_i,
  input  logic              start_instr_i,
  output logic              user_mode_o,
  output logic [WORD_W-1:0] opt_reg_o,
  output logic [WORD_W-1:0] cmd_reg_o,
  output logic              armed_o,
  output logic              crc_clear_o,
  output logic              hdr_err_o
);
  logic              take;
  logic [WORD_W-1:0] word;
  logic              word_vld;
  tgt_e              tgt;
  logic              flush;
  logic              bad;

  assign take = load_sel_i & shift_en_i & ~user_mode_o;

  cfg_deser #(.W(WORD_W)) u_deser (
    .clk_i, .rst_ni, .take_i(take), .bit_i,
    .word_o(word), .word_vld_o(word_vld)
  );

  cfg_hdr_decode #(.W(WORD_W)) u_dec (
    .word_i(word), .tgt_o(tgt), .flush_o(flush), .bad_o(bad)
  );

  cfg_exec #(.W(WORD_W)) u_exec (
    .clk_i, .rst_ni, .word_vld_i(word_vld), .word_i(word),
    .tgt_i(tgt), .bad_i(bad), .opt_o(opt_reg_o), .cmd_o(cmd_reg_o),
    .armed_o, .crc_clr_o(crc_clear_o), .err_o(hdr_err_o)
  );

  cfg_mode_ctrl u_mode (
    .clk_i, .rst_ni, .start_i(start_instr_i), .armed_i(armed_o),
    .user_o(user_mode_o)
  );
endmodule

// File: rtl/cfg_packet_engine_chk.sv
`timescale 1ns/1ps
module cfg_packet_engine_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_instr_i,
  input logic        user_mode_o,
  input logic [31:0] opt_reg_o,
  input logic        armed_o,
  input logic        crc_clear_o,
  input logic        hdr_err_o
);
  a_r6_crc_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_clear_o |=> !crc_clear_o);
  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_err_o |=> hdr_err_o);
  a_r5_armed_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o |=> armed_o);
  a_r9_user_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    user_mode_o |=> user_mode_o);
  a_r10_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_instr_i && !armed_o && !user_mode_o) |=> !user_mode_o);
  a_r9_enter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_instr_i && armed_o) |=> user_mode_o);
  a_r11_opt_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    user_mode_o |=> $stable(opt_reg_o));
endmodule

bind cfg_packet_engine cfg_packet_engine_chk u_chk (
  .clk_i, .rst_ni, .start_instr_i, .user_mode_o, .opt_reg_o,
  .armed_o, .crc_clear_o, .hdr_err_o
);

// File: tb/cfg_packet_engine_test.sv
`timescale 1ns/1ps
module cfg_packet_engine_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic load_sel = 1'b0, shift_en = 1'b0, sbit = 1'b0, start = 1'b0;
  logic user_mode, armed, crc_clr, herr;
  logic [31:0] opt_reg, cmd_reg;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cfg_packet_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .load_sel_i(load_sel), .shift_en_i(shift_en),
    .bit_i(sbit), .start_instr_i(start), .user_mode_o(user_mode),
    .opt_reg_o(opt_reg), .cmd_reg_o(cmd_reg), .armed_o(armed),
    .crc_clear_o(crc_clr), .hdr_err_o(herr)
  );

  typedef struct packed {
    logic [31:0] w, opt, cmd;
    logic err, arm, crc;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{32'h30012001, 32'h0,        32'h0, 1'b0, 1'b0, 1'b0},
    '{32'h00A03FFF, 32'h00A03FFF, 32'h0, 1'b0, 1'b0, 1'b0},
    '{32'h30008001, 32'h00A03FFF, 32'h0, 1'b0, 1'b0, 1'b0},
    '{32'h00000007, 32'h00A03FFF, 32'h7, 1'b0, 1'b0, 1'b1},
    '{32'h00000000, 32'h00A03FFF, 32'h7, 1'b0, 1'b0, 1'b0},
    '{32'h30008001, 32'h00A03FFF, 32'h7, 1'b0, 1'b0, 1'b0},
    '{32'h00000005, 32'h00A03FFF, 32'h5, 1'b0, 1'b1, 1'b0},
    '{32'h00000000, 32'h00A03FFF, 32'h5, 1'b0, 1'b1, 1'b0},
    '{32'h30008001, 32'h00A03FFF, 32'h5, 1'b0, 1'b1, 1'b0},
    '{32'h00000007, 32'h00A03FFF, 32'h7, 1'b0, 1'b1, 1'b1},
    '{32'h00000000, 32'h00A03FFF, 32'h7, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; load_sel = 1'b0; shift_en = 1'b0; start = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Drives 32 bits MSB first; returns at the falling edge after the processing edge.
  task automatic send_word(input logic [31:0] w, input logic sel);
    for (int i = 31; i >= 0; i--) begin
      @(negedge clk);
      load_sel = sel; shift_en = 1'b1; sbit = w[i];
    end
    @(negedge clk);
    shift_en = 1'b0; load_sel = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 user", {31'b0, user_mode}, 32'h0);
    chk("R1 opt", opt_reg, 32'h0);
    chk("R1 cmd", cmd_reg, 32'h0);
    chk("R1 flags", {29'b0, herr, armed, crc_clr}, 32'h0);

    // R10 start without arm
    pulse_start();
    chk("R10 stays config", {31'b0, user_mode}, 32'h0);

    // Table walk: R2 R3 R4 R5 R6 R7
    foreach (VECS[k]) begin
      send_word(VECS[k].w, 1'b1);
      chk("R3 opt", opt_reg, VECS[k].opt);
      chk("R4 cmd", cmd_reg, VECS[k].cmd);
      chk("R5 armed", {31'b0, armed}, {31'b0, VECS[k].arm});
      chk("R6 crc pulse", {31'b0, crc_clr}, {31'b0, VECS[k].crc});
      chk("R7 no err", {31'b0, herr}, {31'b0, VECS[k].err});
      if (VECS[k].crc) begin
        @(negedge clk);
        chk("R6 pulse one cycle", {31'b0, crc_clr}, 32'h0);
      end
    end

    // R9 start with arm
    pulse_start();
    chk("R9 user mode", {31'b0, user_mode}, 32'h1);
    // R11 shifting ignored in user mode
    send_word(32'h30012001, 1'b1);
    send_word(32'h12345678, 1'b1);
    chk("R11 opt frozen", opt_reg, 32'h00A03FFF);
    chk("R11 user holds", {31'b0, user_mode}, 32'h1);

    // R8 bad headers
    do_reset();
    send_word(32'h50012001, 1'b1);
    chk("R8 bad type sets err", {31'b0, herr}, 32'h1);
    send_word(32'h30012001, 1'b1);
    send_word(32'h12345678, 1'b1);
    chk("R8 resumes at header", opt_reg, 32'h12345678);
    do_reset();
    send_word(32'h30002001, 1'b1);
    chk("R8 bad addr sets err", {31'b0, herr}, 32'h1);
    send_word(32'h30008001, 1'b1);
    send_word(32'h00000005, 1'b1);
    chk("R8 err sticky", {31'b0, herr}, 32'h1);
    chk("R8 cmd after bad hdr", cmd_reg, 32'h5);

    // R12 load_sel low ignores bits
    do_reset();
    send_word(32'h50000000, 1'b0);
    send_word(32'h30012001, 1'b0);
    chk("R12 no err", {31'b0, herr}, 32'h0);
    send_word(32'h30012001, 1'b1);
    send_word(32'hCAFEF00D, 1'b1);
    chk("R12 R2 aligned word", opt_reg, 32'hCAFEF00D);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule